// File: doc/BRIEF.md
# Memory Controller Error Interrupt Logger

This block sits beside the datapath of a DDR memory controller. It collects one-cycle event pulses for three error classes: accesses that fall outside the populated address space, correctable ECC events, and uncorrectable ECC events. It also takes a pulse that marks the end of DRAM initialization. For each error class it keeps two sticky flags. One marks the first occurrence. The other marks that the class fired again while the first flag was still set. On the first occurrence of a class, the block also latches the details that come with the pulse: a 33-bit address, plus the access type and length for range errors, or the 64-bit data word and the 8-bit syndrome for ECC events.

Software reaches the block through an indirect register pair. A write to the index port selects one of the 32-bit internal registers. The data port then reads or writes the selected register. A maskable, level-sensitive interrupt stays asserted while any enabled status flag is set. Software clears flags by writing ones to a write-only acknowledge field in the status register.

Top module: `mc_err_logger`

## Requirements
- R1: Writing the index port (`bus_sel`=0) stores `bus_wdata[3:0]`. Reading the index port returns that index zero-extended. Reading or writing the data port (`bus_sel`=1) addresses the register with that index. The index map is: 0 status, 1 mask/type, 2 ECC mode, 3 range length, 4/5 range address low/high, 6/7 uncorrectable address low/high, 8/9 uncorrectable data low/high, 10/11 correctable address low/high, 12/13 correctable data low/high, 14 syndromes. Unmapped indices read zero.
- R2: Register 0 holds the status byte at bits 23:16. A counted event whose first-occurrence flag is clear sets that flag and latches its details. The flags are bit 0 for a range error, bit 2 for a correctable ECC event and bit 4 for an uncorrectable ECC event.
- R3: A counted event whose first-occurrence flag is already set sets the repeat flag of its class (bit 1 range, bit 3 correctable, bit 5 uncorrectable) and leaves the latched details unchanged.
- R4: Status bit 6 is set by the initialization-done pulse. Status bit 7 always reads as the OR of status bits 6 to 0.
- R5: A data-port write to register 0 clears each status bit n (n = 0..6) for which `bus_wdata[24+n]` is 1. The acknowledge field reads as zero. Writing the status field itself has no effect.
- R6: When an event and an acknowledge of the same status bit fall in the same cycle, the event wins and the bit remains set.
- R7: Register 2 bits 1:0 hold the ECC mode: 0 disabled, 1 check only, 2 no ECC storage, 3 check and correct. Correctable and uncorrectable events are counted only in modes 1 and 3. In modes 0 and 2 they change neither the flags nor the latched details.
- R8: Register 1 bits 7:0 hold an interrupt mask, where a 1 enables a source. `irq` is high exactly while some status bit n (n = 0..6) and mask bit n are both 1.
- R9: The latched details are laid out as follows. Address bits 31:0 appear in the low register and address bit 32 in bit 0 of the high register. Data bits 31:0 are in the low data register and bits 63:32 in the high one. The range type is in register 1 bits 10:8 and the range length in register 3 bits 9:0. In register 14, the correctable syndrome is at bits 23:16 and the uncorrectable syndrome at bits 15:8.
- R10: After reset, all flags, mask, mode, index and latched details are zero and `irq` is low.
- R11: Data-port writes to the detail registers (indices 3 to 14) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the selected port |
| bus_sel | input | 1 | 0 selects the index port, 1 the data port |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected port |
| oor_evt | input | 1 | Out-of-range access pulse |
| oor_addr | input | 33 | Address of the out-of-range access |
| oor_type | input | 3 | Type code of the out-of-range access |
| oor_len | input | 10 | Length of the out-of-range access |
| ce_evt | input | 1 | Correctable ECC event pulse |
| ce_addr | input | 33 | Address of the correctable event |
| ce_data | input | 64 | Data word of the correctable event |
| ce_synd | input | 8 | Syndrome of the correctable event |
| ue_evt | input | 1 | Uncorrectable ECC event pulse |
| ue_addr | input | 33 | Address of the uncorrectable event |
| ue_data | input | 64 | Data word of the uncorrectable event |
| ue_synd | input | 8 | Syndrome of the uncorrectable event |
| init_done | input | 1 | Initialization-complete pulse |
| irq | output | 1 | Level interrupt |

## Verification
A software acknowledge of a status bit and a fresh event of the same class can land on the same clock edge. The bench provokes this by raising `oor_evt` in the very cycle of the data-port write that acknowledges the range-error flag, while that flag is already set. It then reads register 0 and expects the first-occurrence flag still set and the repeat flag newly set (status byte 0x83). A second case is an ECC pulse arriving while the mode is 0 or 2. The bench judges that case by reading the status byte and confirming that the flags stay clear.

// File: rtl/mcel_pkg.sv
package mcel_pkg;
  localparam int REG_W   = 32;
  localparam int IDX_W   = 4;
  localparam int DATA_W  = 64;
  localparam int N_CLS   = 3;   // range, correctable, uncorrectable
  localparam int N_SRC   = 7;   // status sources below the summary bit
  localparam int STAT_LSB = 16;
  localparam int ACK_LSB  = 24;
  localparam int TYPE_LSB = 8;
  localparam int CSYN_LSB = 16;
  localparam int USYN_LSB = 8;
  localparam int INIT_BIT = 6;

  typedef enum logic [1:0] {
    ECC_OFF     = 2'd0,
    ECC_CHECK   = 2'd1,
    ECC_NOSTORE = 2'd2,
    ECC_CORRECT = 2'd3
  } ecc_mode_e;

  typedef enum logic [IDX_W-1:0] {
    IX_STATUS = 4'd0,  IX_MASK   = 4'd1,  IX_MODE   = 4'd2,  IX_OORLEN = 4'd3,
    IX_OOR_LO = 4'd4,  IX_OOR_HI = 4'd5,  IX_UE_ALO = 4'd6,  IX_UE_AHI = 4'd7,
    IX_UE_DLO = 4'd8,  IX_UE_DHI = 4'd9,  IX_CE_ALO = 4'd10, IX_CE_AHI = 4'd11,
    IX_CE_DLO = 4'd12, IX_CE_DHI = 4'd13, IX_SYND   = 4'd14
  } reg_idx_e;
endpackage

// File: rtl/mcel_sticky.sv
module mcel_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic ack_one,
  input  logic ack_multi,
  output logic one_q,
  output logic multi_q,
  output logic cap_en
);
  logic one_nxt, multi_nxt;

  // event has priority over a same-cycle acknowledge
  always_comb begin
    one_nxt   = evt | (one_q & ~ack_one);
    multi_nxt = (evt & one_q) | (multi_q & ~ack_multi);
  end

  assign cap_en = evt & ~one_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      one_q   <= 1'b0;
      multi_q <= 1'b0;
    end else begin
      one_q   <= one_nxt;
      multi_q <= multi_nxt;
    end
  end
endmodule

// File: rtl/mcel_capreg.sv
module mcel_capreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb q_nxt = en ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/mc_err_logger.sv
module mc_err_logger
  import mcel_pkg::*;
#(
  parameter int ADDR_W = 33,
  parameter int TYPE_W = 3,
  parameter int LEN_W  = 10,
  parameter int SYND_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_sel,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic                oor_evt,
  input  logic [ADDR_W-1:0]   oor_addr,
  input  logic [TYPE_W-1:0]   oor_type,
  input  logic [LEN_W-1:0]    oor_len,
  input  logic                ce_evt,
  input  logic [ADDR_W-1:0]   ce_addr,
  input  logic [DATA_W-1:0]   ce_data,
  input  logic [SYND_W-1:0]   ce_synd,
  input  logic                ue_evt,
  input  logic [ADDR_W-1:0]   ue_addr,
  input  logic [DATA_W-1:0]   ue_data,
  input  logic [SYND_W-1:0]   ue_synd,
  input  logic                init_done,
  output logic                irq
);
  localparam int AHI_W  = ADDR_W - REG_W;
  localparam int DHI_LSB = REG_W;
  localparam int N_ECC  = 2;   // 0 correctable, 1 uncorrectable

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_core_n = rsync_q[1];

  // register port decode
  logic             idx_en, dwr;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic [N_SRC-1:0] ack;
  logic             mask_en, mode_en;
  logic [7:0]       mask_q, mask_nxt;
  logic [1:0]       mode_q, mode_nxt;
  logic             ecc_live;
  logic             unused_wbits;

  assign idx_en  = bus_wr & ~bus_sel;
  assign dwr     = bus_wr &  bus_sel;
  assign mask_en = dwr && (idx_q == IX_MASK);
  assign mode_en = dwr && (idx_q == IX_MODE);
  assign ack     = (dwr && (idx_q == IX_STATUS)) ? bus_wdata[ACK_LSB +: N_SRC] : '0;
  assign unused_wbits = ^{bus_wdata[REG_W-1], bus_wdata[ACK_LSB-1:8]};

  always_comb begin
    idx_nxt  = idx_en  ? bus_wdata[IDX_W-1:0] : idx_q;
    mask_nxt = mask_en ? bus_wdata[7:0]       : mask_q;
    mode_nxt = mode_en ? bus_wdata[1:0]       : mode_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      idx_q  <= '0;
      mask_q <= '0;
      mode_q <= '0;
    end else begin
      idx_q  <= idx_nxt;
      mask_q <= mask_nxt;
      mode_q <= mode_nxt;
    end
  end

  assign ecc_live = (mode_q == ECC_CHECK) || (mode_q == ECC_CORRECT);

  // per-class sticky flags
  logic [N_CLS-1:0] cls_evt, cls_one, cls_multi, cls_cap;
  assign cls_evt = {ue_evt & ecc_live, ce_evt & ecc_live, oor_evt};

  for (genvar c = 0; c < N_CLS; c++) begin : g_cls
    mcel_sticky u_sticky (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .evt      (cls_evt[c]),
      .ack_one  (ack[2*c]),
      .ack_multi(ack[2*c+1]),
      .one_q    (cls_one[c]),
      .multi_q  (cls_multi[c]),
      .cap_en   (cls_cap[c])
    );
  end

  logic init_q, init_nxt;
  always_comb init_nxt = init_done | (init_q & ~ack[INIT_BIT]);
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) init_q <= 1'b0;
    else             init_q <= init_nxt;
  end

  logic [N_SRC-1:0] stat7;
  logic [7:0]       stat8;
  assign stat7 = {init_q, cls_multi[2], cls_one[2], cls_multi[1], cls_one[1],
                  cls_multi[0], cls_one[0]};
  assign stat8 = {|stat7, stat7};
  assign irq   = |(stat7 & mask_q[N_SRC-1:0]);

  // range-error details
  logic [ADDR_W-1:0] oor_addr_q;
  logic [TYPE_W-1:0] oor_type_q;
  logic [LEN_W-1:0]  oor_len_q;

  mcel_capreg #(.W(ADDR_W)) u_oor_addr (.clk(clk), .rst_n(rst_core_n), .en(cls_cap[0]),
                                        .d(oor_addr), .q(oor_addr_q));
  mcel_capreg #(.W(TYPE_W)) u_oor_type (.clk(clk), .rst_n(rst_core_n), .en(cls_cap[0]),
                                        .d(oor_type), .q(oor_type_q));
  mcel_capreg #(.W(LEN_W))  u_oor_len  (.clk(clk), .rst_n(rst_core_n), .en(cls_cap[0]),
                                        .d(oor_len), .q(oor_len_q));

  // ECC details, one set per ECC class
  logic [ADDR_W-1:0] ecc_addr_d [N_ECC];
  logic [ADDR_W-1:0] ecc_addr_q [N_ECC];
  logic [DATA_W-1:0] ecc_data_d [N_ECC];
  logic [DATA_W-1:0] ecc_data_q [N_ECC];
  logic [SYND_W-1:0] ecc_synd_d [N_ECC];
  logic [SYND_W-1:0] ecc_synd_q [N_ECC];

  assign ecc_addr_d[0] = ce_addr;  assign ecc_addr_d[1] = ue_addr;
  assign ecc_data_d[0] = ce_data;  assign ecc_data_d[1] = ue_data;
  assign ecc_synd_d[0] = ce_synd;  assign ecc_synd_d[1] = ue_synd;

  for (genvar e = 0; e < N_ECC; e++) begin : g_ecc
    mcel_capreg #(.W(ADDR_W)) u_addr (.clk(clk), .rst_n(rst_core_n), .en(cls_cap[e+1]),
                                      .d(ecc_addr_d[e]), .q(ecc_addr_q[e]));
    mcel_capreg #(.W(DATA_W)) u_data (.clk(clk), .rst_n(rst_core_n), .en(cls_cap[e+1]),
                                      .d(ecc_data_d[e]), .q(ecc_data_q[e]));
    mcel_capreg #(.W(SYND_W)) u_synd (.clk(clk), .rst_n(rst_core_n), .en(cls_cap[e+1]),
                                      .d(ecc_synd_d[e]), .q(ecc_synd_q[e]));
  end

  // read mux
  logic [REG_W-1:0] rd_data;
  always_comb begin
    rd_data = '0;
    case (idx_q)
      IX_STATUS: rd_data = REG_W'(stat8) << STAT_LSB;
      IX_MASK:   rd_data = REG_W'(mask_q) | (REG_W'(oor_type_q) << TYPE_LSB);
      IX_MODE:   rd_data = REG_W'(mode_q);
      IX_OORLEN: rd_data = REG_W'(oor_len_q);
      IX_OOR_LO: rd_data = oor_addr_q[REG_W-1:0];
      IX_OOR_HI: rd_data = REG_W'(oor_addr_q[REG_W +: AHI_W]);
      IX_UE_ALO: rd_data = ecc_addr_q[1][REG_W-1:0];
      IX_UE_AHI: rd_data = REG_W'(ecc_addr_q[1][REG_W +: AHI_W]);
      IX_UE_DLO: rd_data = ecc_data_q[1][REG_W-1:0];
      IX_UE_DHI: rd_data = ecc_data_q[1][DHI_LSB +: REG_W];
      IX_CE_ALO: rd_data = ecc_addr_q[0][REG_W-1:0];
      IX_CE_AHI: rd_data = REG_W'(ecc_addr_q[0][REG_W +: AHI_W]);
      IX_CE_DLO: rd_data = ecc_data_q[0][REG_W-1:0];
      IX_CE_DHI: rd_data = ecc_data_q[0][DHI_LSB +: REG_W];
      IX_SYND:   rd_data = (REG_W'(ecc_synd_q[0]) << CSYN_LSB) |
                           (REG_W'(ecc_synd_q[1]) << USYN_LSB);
      default:   rd_data = '0;
    endcase
  end

  assign bus_rdata = bus_sel ? rd_data : REG_W'(idx_q);
endmodule

// File: rtl/mcel_chk.sv
module mcel_chk #(
  parameter int ADDR_W = 33
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oor_evt,
  input logic              init_done,
  input logic [1:0]        mode,
  input logic [6:0]        stat,
  input logic [6:0]        ack,
  input logic [7:0]        mask,
  input logic [ADDR_W-1:0] oor_addr_cap,
  input logic              irq
);
  // R2
  oor_first_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oor_evt |=> stat[0]);

  // R3
  oor_repeat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oor_evt && stat[0]) |=> stat[1]);

  // R3
  oor_detail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat[0] |=> $stable(oor_addr_cap));

  // R6
  ack_vs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[0] && oor_evt) |=> stat[0]);

  // R5
  init_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[6] && !init_done) |=> !stat[6]);

  // R7
  ce_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[0] && !stat[2]) |=> !stat[2]);

  // R7
  ue_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[0] && !stat[4]) |=> !stat[4]);

  // R8
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[6:0] == 7'd0) |-> !irq);
endmodule

bind mc_err_logger mcel_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .oor_evt     (oor_evt),
  .init_done   (init_done),
  .mode        (mode_q),
  .stat        (stat7),
  .ack         (ack),
  .mask        (mask_q),
  .oor_addr_cap(oor_addr_q),
  .irq         (irq)
);

// File: tb/mc_err_logger_tb_top.sv
`timescale 1ns/1ps
module mc_err_logger_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_sel;
  logic [31:0] bus_wdata, bus_rdata;
  logic        oor_evt, ce_evt, ue_evt, init_done;
  logic [32:0] oor_addr, ce_addr, ue_addr;
  logic [2:0]  oor_type;
  logic [9:0]  oor_len;
  logic [63:0] ce_data, ue_data;
  logic [7:0]  ce_synd, ue_synd;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  mc_err_logger dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .oor_evt(oor_evt), .oor_addr(oor_addr), .oor_type(oor_type), .oor_len(oor_len),
    .ce_evt(ce_evt), .ce_addr(ce_addr), .ce_data(ce_data), .ce_synd(ce_synd),
    .ue_evt(ue_evt), .ue_addr(ue_addr), .ue_data(ue_data), .ue_synd(ue_synd),
    .init_done(init_done), .irq(irq)
  );

  // {mode[1:0], events{oor,ce,ue}[2:0], pulses[2:0], expected status byte[7:0]}
  localparam logic [15:0] VEC [9] = '{
    16'hE181,  // R2 range once, mode 3
    16'hE283,  // R3 range twice
    16'hD184,  // R2 correctable once
    16'hD38C,  // R3 correctable three times
    16'h4990,  // R2 uncorrectable once, mode 1
    16'h5ABC,  // R3 both ECC classes twice
    16'h1A00,  // R7 mode 0 ignores ECC
    16'hB981,  // R7 mode 2 ignores ECC, range still logs
    16'h8A00   // R7 mode 2 uncorrectable twice
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic wreg(input int ix, input logic [31:0] d);
    wr(1'b0, 32'(ix));
    wr(1'b1, d);
  endtask

  task automatic rdreg(input int ix, output logic [31:0] d);
    wr(1'b0, 32'(ix));
    bus_sel = 1'b1;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [2:0] ev);
    @(negedge clk);
    {oor_evt, ce_evt, ue_evt} = ev;
    @(negedge clk);
    {oor_evt, ce_evt, ue_evt} = 3'b000;
  endtask

  task automatic ack_all();
    wreg(0, 32'h7F00_0000);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_wr = 0; bus_sel = 0; bus_wdata = 0;
    oor_evt = 0; ce_evt = 0; ue_evt = 0; init_done = 0;
    oor_addr = 0; oor_type = 0; oor_len = 0;
    ce_addr = 0; ce_data = 0; ce_synd = 0;
    ue_addr = 0; ue_data = 0; ue_synd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    #1 chk("R10 index after reset", bus_rdata, 32'h0);
    chk("R10 irq after reset", {31'b0, irq}, 32'h0);
    rdreg(0, d); chk("R10 status after reset", d, 32'h0);
    rdreg(1, d); chk("R10 mask after reset", d, 32'h0);
    rdreg(2, d); chk("R10 mode after reset", d, 32'h0);
    rdreg(4, d); chk("R10 range address after reset", d, 32'h0);

    // R1 index port readback, unmapped index
    wr(1'b0, 32'h0000_0005); bus_sel = 1'b0;
    #1 chk("R1 index readback", bus_rdata, 32'h5);
    rdreg(15, d); chk("R1 unmapped index", d, 32'h0);

    // vector table: R2 R3 R7
    for (int v = 0; v < 9; v++) begin
      logic [15:0] e;
      e = VEC[v];
      wreg(2, {30'b0, e[15:14]});
      ack_all();
      for (int n = 0; n < int'(e[10:8]); n++) pulse(e[13:11]);
      rdreg(0, d);
      chk($sformatf("R2 R3 R7 vector %0d status", v), {24'b0, d[23:16]}, {24'b0, e[7:0]});
    end

    // R9 detail capture and R3 hold
    wreg(2, 32'h3);
    ack_all();
    oor_addr = 33'h1_DEAD_BEEF; oor_type = 3'd5; oor_len = 10'h2AB;
    pulse(3'b100);
    oor_addr = 33'h0_1111_2222; oor_type = 3'd2; oor_len = 10'h003;
    pulse(3'b100);
    rdreg(4, d); chk("R9 R3 range address low held", d, 32'hDEAD_BEEF);
    rdreg(5, d); chk("R9 range address bit 32", d, 32'h1);
    rdreg(1, d); chk("R9 range type", {29'b0, d[10:8]}, 32'h5);
    rdreg(3, d); chk("R9 range length", d, 32'h2AB);

    ce_addr = 33'h0_1234_5678; ce_data = 64'hCAFE_F00D_0123_4567; ce_synd = 8'h5A;
    ue_addr = 33'h1_0000_0010; ue_data = 64'h0BAD_0000_FFFF_1234; ue_synd = 8'hC3;
    pulse(3'b011);
    rdreg(6, d);  chk("R9 ue address low", d, 32'h0000_0010);
    rdreg(7, d);  chk("R9 ue address high", d, 32'h1);
    rdreg(8, d);  chk("R9 ue data low", d, 32'hFFFF_1234);
    rdreg(9, d);  chk("R9 ue data high", d, 32'h0BAD_0000);
    rdreg(10, d); chk("R9 ce address low", d, 32'h1234_5678);
    rdreg(11, d); chk("R9 ce address high", d, 32'h0);
    rdreg(12, d); chk("R9 ce data low", d, 32'h0123_4567);
    rdreg(13, d); chk("R9 ce data high", d, 32'hCAFE_F00D);
    rdreg(14, d); chk("R9 syndromes", d, 32'h005A_C300);

    // R11 detail registers are read-only
    wreg(4, 32'h0);
    wreg(14, 32'hFFFF_FFFF);
    rdreg(4, d);  chk("R11 write to range address ignored", d, 32'hDEAD_BEEF);
    rdreg(14, d); chk("R11 write to syndromes ignored", d, 32'h005A_C300);

    // R5 status field write has no effect, acknowledge clears selected bit
    wreg(0, 32'h00FF_0000);
    rdreg(0, d); chk("R5 status field not writable", d, 32'h0097_0000);
    wreg(0, 32'h0200_0000);
    rdreg(0, d); chk("R5 acknowledge bit 1", d, 32'h0095_0000);

    // R4 init flag and summary bit
    @(negedge clk); init_done = 1'b1;
    @(negedge clk); init_done = 1'b0;
    rdreg(0, d); chk("R4 init flag set", d, 32'h00D5_0000);
    ack_all();
    rdreg(0, d); chk("R4 summary clears with all", d, 32'h0);
    @(negedge clk); init_done = 1'b1;
    @(negedge clk); init_done = 1'b0;
    rdreg(0, d); chk("R4 init alone sets summary", d, 32'h00C0_0000);

    // R6 acknowledge and event in one cycle
    ack_all();
    pulse(3'b100);
    wr(1'b0, 32'h0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wdata = 32'h0100_0000; bus_wr = 1'b1; oor_evt = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; oor_evt = 1'b0;
    #1 chk("R6 event beats acknowledge", {24'b0, bus_rdata[23:16]}, 32'h83);

    // R8 interrupt masking
    ack_all();
    pulse(3'b100);
    wreg(1, 32'h0);
    #1 chk("R8 irq masked off", {31'b0, irq}, 32'h0);
    wreg(1, 32'h1);
    #1 chk("R8 irq enabled source", {31'b0, irq}, 32'h1);
    rdreg(1, d); chk("R8 mask readback", {24'b0, d[7:0]}, 32'h01);
    wreg(1, 32'hFE);
    #1 chk("R8 irq other sources only", {31'b0, irq}, 32'h0);
    wreg(1, 32'hFF);
    #1 chk("R8 irq all enabled", {31'b0, irq}, 32'h1);
    ack_all();
    #1 chk("R8 irq drops after acknowledge", {31'b0, irq}, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule